// File: doc/BRIEF.md
# Paged Nonvolatile Data Memory Controller

This block is a register-mapped controller for a small data store that is organised in pages of four bytes. Software stages a page number and up to four data bytes through an 8-bit register port. It then writes a command code that reads, programs, compares or erases that page, or erases the whole array. The controller owns the array model and runs each operation for a fixed number of clock cycles. During that time it reports busy, and afterwards it reports done. A page comparison leaves a per-byte mismatch mask that software can read back.

The storage model behaves like a flash cell. An erased byte reads as FFh. Programming can only clear bits, so a second program of the same page stores the AND of the old and new values. Erasure works page-wide or array-wide. While an operation is in progress, the staging registers, the page number and the command register are locked. Any command that arrives in that time is refused and raises an error flag.

Top module: `pgmem_ctrl`

## Requirements
- R1: After reset the status register reads 00h, busy_o and done_o are low, the data and page registers read 00h, and every page of the array reads FFh in all four bytes.
- R2: Register offsets on reg_addr_i: 0..3 are data bytes 0..3 (byte i is bits 8i+7:8i of the page word); 4 is page number bits 7:0; 5 is page number bits 9:8 in its bits 1:0, with bits 7:2 reading 0; a write to 6 issues a command and a read of 6 returns the last compare result; 7 is status with bit0 busy, bit1 done, bit2 error and bits 7:3 zero.
- R3: The command codes are 01h read, 02h write, 04h verify, 05h page erase and 06h erase-all. An accepted command raises busy on the clock edge that takes it. Busy then stays high for RD_CYC cycles (read, verify), WR_CYC cycles (write), ER_CYC cycles (page erase) or EA_CYC cycles (erase-all). Busy falls and done rises on the same edge.
- R4: A read copies the four bytes of the addressed page into data registers 0..3 when it completes.
- R5: A write changes the addressed page to the bitwise AND of its previous contents and the staged bytes.
- R6: A page erase sets all four bytes of the addressed page to FFh and leaves the other pages unchanged.
- R7: Erase-all sets every byte of every page to FFh.
- R8: Verify compares the staged bytes with the addressed page. The compare result is 00h on a full match. Otherwise bit i is set for each byte i that differs, and bits 7:4 are 0.
- R9: A write of any other code to offset 6 starts nothing, leaves busy low, sets the error bit and leaves the done bit as it was.
- R10: While busy, a command write is refused and sets the error bit, and writes to offsets 0..5 are ignored; the running operation completes unchanged.
- R11: An accepted command clears both the done bit and the error bit on the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last accepted operation has completed |

## Verification
The assertions check several rules on every cycle. Busy must follow an accepted command. Busy must fall only with done set. A refused or unknown command must raise the error flag without starting work, and an accepted one must clear done and error. Staging bytes must hold steady while busy. Page and whole-array erasure must leave the blank state behind, and a program must clear it. Some behaviour can only be shown by the bench scenarios: the exact busy length for each operation, the AND rule for programming over an earlier value, the per-byte verify mask, that neighbouring pages survive a page erase, and the edge pages at 0 and 1023.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;

  localparam int unsigned PAGE_BYTES = 4;
  localparam int unsigned PAGE_BITS  = PAGE_BYTES * 8;

  typedef enum logic [7:0] {
    CMD_READ      = 8'h01,
    CMD_WRITE     = 8'h02,
    CMD_VERIFY    = 8'h04,
    CMD_ERASE     = 8'h05,
    CMD_ERASE_ALL = 8'h06
  } cmd_e;

  localparam logic [2:0] REG_PAGE_LO = 3'd4;
  localparam logic [2:0] REG_PAGE_HI = 3'd5;
  localparam logic [2:0] REG_CMD     = 3'd6;
  localparam logic [2:0] REG_STATUS  = 3'd7;

  function automatic logic code_valid(input logic [7:0] c);
    return (c == CMD_READ) || (c == CMD_WRITE) || (c == CMD_VERIFY) ||
           (c == CMD_ERASE) || (c == CMD_ERASE_ALL);
  endfunction

endpackage

// File: rtl/pgmem_array.sv
module pgmem_array
  import pgmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [PAGE_BITS-1:0] wr_data_i,
  input  logic                 erase_pg_i,
  input  logic                 erase_all_i,
  output logic [PAGE_BITS-1:0] rd_data_o
);

  localparam int unsigned PAGES = 1 << ADDR_W;

  logic [PAGE_BITS-1:0] mem_q [PAGES];
  logic [PAGES-1:0]     blank_q;

  // blank pages read as all ones without touching the storage
  assign rd_data_o = blank_q[addr_i] ? '1 : mem_q[addr_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= rd_data_o & wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= '1;
    end else if (erase_all_i) begin
      blank_q <= '1;
    end else if (erase_pg_i) begin
      blank_q[addr_i] <= 1'b1;
    end else if (wr_en_i) begin
      blank_q[addr_i] <= 1'b0;
    end
  end

  assert_erase_all_blank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_all_i |=> (&blank_q));

  assert_erase_page_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_pg_i && !erase_all_i) |=> blank_q[$past(addr_i)]);

  assert_write_unblanks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !erase_pg_i && !erase_all_i) |=> !blank_q[$past(addr_i)]);

endmodule

// File: rtl/pgmem_regfile.sv
module pgmem_regfile
  import pgmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [2:0]           addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 busy_i,
  input  logic                 load_en_i,
  input  logic [PAGE_BITS-1:0] load_data_i,
  input  logic [7:0]           vres_i,
  input  logic [7:0]           status_i,
  output logic [7:0]           rdata_o,
  output logic [ADDR_W-1:0]    page_o,
  output logic [PAGE_BITS-1:0] stage_o
);

  localparam int unsigned HI_W = ADDR_W - 8;

  logic [PAGE_BYTES-1:0][7:0] stage_q;
  logic [7:0]                 lo_q;
  logic [HI_W-1:0]            hi_q;
  logic                       sw_we;

  assign sw_we = we_i && !busy_i;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[i] <= '0;
      end else if (load_en_i) begin
        stage_q[i] <= load_data_i[i*8 +: 8];
      end else if (sw_we && addr_i == 3'(i)) begin
        stage_q[i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (sw_we) begin
      if (addr_i == REG_PAGE_LO) lo_q <= wdata_i;
      if (addr_i == REG_PAGE_HI) hi_q <= wdata_i[HI_W-1:0];
    end
  end

  assign page_o  = {hi_q, lo_q};
  assign stage_o = stage_q;

  always_comb begin
    case (addr_i)
      REG_PAGE_LO: rdata_o = lo_q;
      REG_PAGE_HI: rdata_o = 8'(hi_q);
      REG_CMD:     rdata_o = vres_i;
      REG_STATUS:  rdata_o = status_i;
      default:     rdata_o = stage_q[addr_i[1:0]];
    endcase
  end

  assert_stage_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i && !addr_i[2] && !load_en_i) |=> $stable(stage_q));

  assert_page_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i) |=> $stable(page_o));

endmodule

// File: rtl/pgmem_seq.sv
module pgmem_seq
  import pgmem_pkg::*;
#(
  parameter int unsigned RD_CYC = 4,
  parameter int unsigned WR_CYC = 16,
  parameter int unsigned ER_CYC = 64,
  parameter int unsigned EA_CYC = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_we_i,
  input  logic [7:0]           cmd_i,
  input  logic [PAGE_BITS-1:0] stage_i,
  input  logic [PAGE_BITS-1:0] arr_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [7:0]           vres_o,
  output logic                 arr_wr_o,
  output logic                 arr_erase_o,
  output logic                 arr_erase_all_o,
  output logic                 load_en_o
);

  localparam int unsigned MAX_AB  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned MAX_CD  = (ER_CYC > EA_CYC) ? ER_CYC : EA_CYC;
  localparam int unsigned MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC) + 1;

  cmd_e             op_q;
  logic             busy_q, done_q, err_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       vres_q;
  logic [7:0]       mismatch;
  logic             finish;
  logic             code_ok;

  function automatic logic [CNT_W-1:0] lat_of(input logic [7:0] c);
    case (c)
      CMD_WRITE:     return CNT_W'(WR_CYC - 1);
      CMD_ERASE:     return CNT_W'(ER_CYC - 1);
      CMD_ERASE_ALL: return CNT_W'(EA_CYC - 1);
      default:       return CNT_W'(RD_CYC - 1);
    endcase
  endfunction

  assign code_ok = code_valid(cmd_i);
  assign finish  = busy_q && (cnt_q == '0);

  always_comb begin
    mismatch = '0;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      mismatch[i] = stage_i[i*8 +: 8] != arr_i[i*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= CMD_READ;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      vres_q <= '0;
    end else begin
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (op_q == CMD_VERIFY) vres_q <= mismatch;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (cmd_we_i) begin
        if (busy_q || !code_ok) begin
          err_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          op_q   <= cmd_e'(cmd_i);
          cnt_q  <= lat_of(cmd_i);
          done_q <= 1'b0;
          err_q  <= 1'b0;
        end
      end
    end
  end

  assign busy_o          = busy_q;
  assign done_o          = done_q;
  assign err_o           = err_q;
  assign vres_o          = vres_q;
  assign arr_wr_o        = finish && (op_q == CMD_WRITE);
  assign arr_erase_o     = finish && (op_q == CMD_ERASE);
  assign arr_erase_all_o = finish && (op_q == CMD_ERASE_ALL);
  assign load_en_o       = finish && (op_q == CMD_READ);

  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_o && code_valid(cmd_i)) |=> busy_o);

  assert_done_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CNT_W'(MAX_CYC)));

  assert_bad_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_o && !code_valid(cmd_i)) |=> (err_o && !busy_o));

  assert_reject_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && busy_o && cnt_q != '0) |=> (busy_o && err_o));

  assert_clear_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_o && code_valid(cmd_i)) |=> (!done_o && !err_o));

endmodule

// File: rtl/pgmem_ctrl.sv
module pgmem_ctrl
  import pgmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned RD_CYC = 4,
  parameter int unsigned WR_CYC = 16,
  parameter int unsigned ER_CYC = 64,
  parameter int unsigned EA_CYC = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       busy_o,
  output logic       done_o
);

  logic [ADDR_W-1:0]    page;
  logic [PAGE_BITS-1:0] stage, arr_rd;
  logic                 busy, done, err;
  logic [7:0]           vres, status;
  logic                 arr_wr, arr_erase, arr_erase_all, load_en;
  logic                 cmd_we;

  assign cmd_we = reg_we_i && (reg_addr_i == REG_CMD);
  assign status = {5'b0, err, done, busy};

  pgmem_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy),
    .load_en_i   (load_en),
    .load_data_i (arr_rd),
    .vres_i      (vres),
    .status_i    (status),
    .rdata_o     (reg_rdata_o),
    .page_o      (page),
    .stage_o     (stage)
  );

  pgmem_seq #(
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .ER_CYC(ER_CYC), .EA_CYC(EA_CYC)
  ) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cmd_we_i        (cmd_we),
    .cmd_i           (reg_wdata_i),
    .stage_i         (stage),
    .arr_i           (arr_rd),
    .busy_o          (busy),
    .done_o          (done),
    .err_o           (err),
    .vres_o          (vres),
    .arr_wr_o        (arr_wr),
    .arr_erase_o     (arr_erase),
    .arr_erase_all_o (arr_erase_all),
    .load_en_o       (load_en)
  );

  pgmem_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (page),
    .wr_en_i     (arr_wr),
    .wr_data_i   (stage),
    .erase_pg_i  (arr_erase),
    .erase_all_i (arr_erase_all),
    .rd_data_o   (arr_rd)
  );

  assign busy_o = busy;
  assign done_o = done;

endmodule

// File: tb/sim_pgmem_ctrl.sv
module sim_pgmem_ctrl;

  localparam int RD = 3, WR = 5, ER = 8, EA = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy, done;

  always #2 clk = ~clk;

  pgmem_ctrl #(.ADDR_W(10), .RD_CYC(RD), .WR_CYC(WR), .ER_CYC(ER), .EA_CYC(EA)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy), .done_o(done)
  );

  typedef struct {
    logic [2:0] a;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit [31:0] model [1024];

  // monitor: compares register reads in scoreboard order
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_tests++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s reg%0d actual=%02h expected=%02h", it.tag, it.a, rdata, it.exp);
      end
    end
  end

  // all tasks start and end just after a rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    addr = a;
    it.a = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int e, input string tag);
    n_tests++;
    if (act != e) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, e);
    end
  endtask

  task automatic set_page(input int p);
    wr(3'd4, 8'(p));
    wr(3'd5, 8'(p >> 8));
  endtask

  task automatic stage(input bit [31:0] d);
    for (int i = 0; i < 4; i++) wr(3'(i), d[i*8 +: 8]);
  endtask

  task automatic run(input logic [7:0] c, input int lat, input string tag);
    int n = 0;
    wr(3'd6, c);
    while (busy) begin
      n++;
      @(posedge clk); #1;
    end
    chk(n, lat, tag);
  endtask

  task automatic check_page(input int p, input string tag);
    set_page(p);
    run(8'h01, RD, {tag, " R3 read busy"});
    for (int i = 0; i < 4; i++) rd_chk(3'(i), model[p][i*8 +: 8], {tag, " R4"});
  endtask

  task automatic write_page(input int p, input bit [31:0] d);
    set_page(p);
    stage(d);
    run(8'h02, WR, "R3 write busy");
    model[p] = model[p] & d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk(3'd7, 8'h00, "R1 status");
    chk(busy, 0, "R1 busy_o");
    chk(done, 0, "R1 done_o");
    rd_chk(3'd0, 8'h00, "R1 data0");
    rd_chk(3'd4, 8'h00, "R1 page lo");
    rd_chk(3'd6, 8'h00, "R2 compare result after reset");
    check_page(0, "R1 blank page 0");

    // R2 high page bits
    wr(3'd5, 8'hFF);
    rd_chk(3'd5, 8'h03, "R2 page hi width");

    // R3 R4 R5 write then read back
    write_page(5, 32'h7856_3412);
    rd_chk(3'd7, 8'h02, "R3 done after write");
    stage(32'h0);
    check_page(5, "R5 first program");
    write_page(5, 32'hF0F0_F0F0);
    stage(32'h0);
    check_page(5, "R5 AND on reprogram");

    // R8 verify
    stage(32'h7050_3010);
    run(8'h04, RD, "R3 verify busy");
    rd_chk(3'd6, 8'h00, "R8 verify match");
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h11);
    run(8'h04, RD, "R3 verify busy");
    rd_chk(3'd6, 8'h05, "R8 verify mismatch mask");

    // R6 page erase leaves neighbour intact
    write_page(6, 32'hAAAA_AAAA);
    set_page(5);
    run(8'h05, ER, "R3 page erase busy");
    model[5] = 32'hFFFF_FFFF;
    check_page(5, "R6 erased page");
    check_page(6, "R6 neighbour page");

    // R9 unknown code: done stays, error set, nothing starts
    wr(3'd6, 8'h03);
    chk(busy, 0, "R9 busy after bad code");
    rd_chk(3'd7, 8'h06, "R9 status after bad code");

    // R10 writes during busy ignored, R11 flags cleared on accept
    wr(3'd6, 8'h05);
    rd_chk(3'd7, 8'h01, "R11 done and error cleared on accept");
    wr(3'd0, 8'h55);
    wr(3'd4, 8'h09);
    wr(3'd6, 8'h02);
    while (busy) begin @(posedge clk); #1; end
    model[6] = 32'hFFFF_FFFF;
    rd_chk(3'd7, 8'h06, "R10 error after refused command");
    rd_chk(3'd0, 8'hAA, "R10 data0 held");
    rd_chk(3'd4, 8'h06, "R10 page held");
    check_page(6, "R10 erase ran on held page");
    rd_chk(3'd7, 8'h02, "R11 error cleared by next command");
    check_page(9, "R10 page 9 untouched");

    // R7 erase-all, including the last page
    write_page(1023, 32'h0403_0201);
    check_page(1023, "R5 last page");
    write_page(2, 32'h0);
    run(8'h06, EA, "R3 erase-all busy");
    for (int i = 0; i < 1024; i++) model[i] = 32'hFFFF_FFFF;
    check_page(1023, "R7 last page");
    check_page(2, "R7 page 2");
    check_page(6, "R7 page 6");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule